// File: doc/BRIEF.md
# Variable-Page Address Translator

This block turns a 32-bit virtual address into a physical address for a data read, a data write or an instruction fetch. It applies three stages in a fixed order. First come the fixed address windows: two are mapped directly and need no table lookup, and part of them is closed to user mode. Next, if translation is switched off, the address is mapped flat. Only after that does it search a small fully associative translation table. Each table entry has its own page size (1 KB, 4 KB, 64 KB or 1 MB), an address-space identifier, a share flag, two protection bits and a dirty flag.

The block decodes the request combinationally and registers the result. The cycle after a request it presents either a physical address or a fault with a 12-bit exception code. Each fault class has its own code: miss, protection violation, first write to a clean page, multiple hit and region violation. Table entries are loaded through a simple indexed write port. Refill from page tables is done elsewhere.

Top module: `vtlb_xlate`

## Requirements
- R1: A request is presented with `req_valid`, and its result appears one cycle later with `rsp_valid` high. `rsp_valid` is low in every cycle that does not follow a request, including the first cycle after reset. `req_kind` encodes 0 = read, 1 = write and 2 = fetch; the value 3 is treated as a read.
- R2: A privileged access to 0x80000000–0xBFFFFFFF never faults, and its physical address is the low 29 bits of the virtual address (upper three bits zero).
- R3: A privileged access at or above 0xE0000000 never faults and passes through unchanged. A user access to 0xE0000000–0xE3FFFFFF behaves the same way.
- R4: A user access to 0x80000000–0xBFFFFFFF, or to 0xE4000000 and above, faults with code 0x100 for a write and 0x0E0 for a read or fetch. This applies whether translation is on or off.
- R5: With `xlate_en` low, every address below 0x80000000 or in 0xC0000000–0xDFFFFFFF maps to its low 29 bits, with no fault, for any access kind and mode.
- R6: Entry size code 0/1/2/3 selects a page of 1 KB, 4 KB, 64 KB or 1 MB. Page numbers are aligned at address bit 10, and their bits below the page size are ignored for both the VPN and the PPN. The physical address is the aligned PPN ORed with the in-page offset of the virtual address. A write on the entry port replaces the entry at `wr_index` from the next cycle.
- R7: An entry matches only when it is valid, the address lies in its page, and the identifier test passes. The identifier test passes when the entry is shared, when `single_virt` is high and the access is privileged, or when the entry identifier equals `cur_asid`.
- R8: With translation on and no matching entry, the fault code is 0x060 for a write and 0x040 for a read or fetch. This includes 0xC0000000–0xDFFFFFFF.
- R9: Two or more matching entries give fault code 0x140.
- R10: A user access to a matching entry whose protection bit 1 is clear faults with 0x0C0 for a write and 0x0A0 for a read or fetch.
- R11: A write that passes R10 but hits an entry with protection bit 0 clear faults with 0x0C0. If it passes that check but the entry's dirty flag is clear, it faults with 0x080. Reads and fetches ignore both bits.
- R12: Reset invalidates every entry, so a translated access after reset misses.
- R13: A faulting response drives `rsp_paddr` to zero and carries one of the eight listed codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | 1 = privileged mode |
| cur_asid | input | 8 | Current address-space identifier |
| xlate_en | input | 1 | Translation enable |
| single_virt | input | 1 | Single-virtual mode: privileged accesses skip the identifier test |
| wr_en | input | 1 | Entry write strobe |
| wr_index | input | IDX_W | Entry slot to write |
| wr_vpn | input | 22 | Virtual page number (address bits 31:10) |
| wr_ppn | input | 22 | Physical page number (address bits 31:10) |
| wr_asid | input | 8 | Entry identifier |
| wr_size | input | 2 | Page size code |
| wr_valid | input | 1 | Entry valid |
| wr_share | input | 1 | Entry shared by all identifiers |
| wr_prot | input | 2 | Bit 1 user access allowed, bit 0 write allowed |
| wr_dirty | input | 1 | Page already written |
| rsp_valid | output | 1 | Result strobe, one cycle after request |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 12 | Exception code when faulting |
| rsp_paddr | output | 32 | Physical address, zero on fault |

## Verification
Each translation result is due exactly one clock edge after the edge that samples its request. An entry write takes effect at the edge that samples it, so a lookup presented afterwards sees the new entry. The bench drives every input on the falling edge and reads the response on the next falling edge. That lands half a cycle after the registering edge and before the next one. Between requests it inserts an idle cycle so that `rsp_valid` can be seen to drop.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    localparam int VA_W   = 32;
    localparam int PN_W   = 22;
    localparam int OFS_W  = VA_W - PN_W;
    localparam int ASID_W = 8;
    localparam int CODE_W = 12;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam logic [CODE_W-1:0] EXC_MISS_RD  = 12'h040;
    localparam logic [CODE_W-1:0] EXC_MISS_WR  = 12'h060;
    localparam logic [CODE_W-1:0] EXC_FIRST_WR = 12'h080;
    localparam logic [CODE_W-1:0] EXC_PROT_RD  = 12'h0A0;
    localparam logic [CODE_W-1:0] EXC_PROT_WR  = 12'h0C0;
    localparam logic [CODE_W-1:0] EXC_ADDR_RD  = 12'h0E0;
    localparam logic [CODE_W-1:0] EXC_ADDR_WR  = 12'h100;
    localparam logic [CODE_W-1:0] EXC_MULTI    = 12'h140;

    typedef struct packed {
        logic              valid;
        logic              share;
        logic [1:0]        size;
        logic [1:0]        prot;
        logic              dirty;
        logic [ASID_W-1:0] asid;
        logic [PN_W-1:0]   vpn;
        logic [PN_W-1:0]   ppn;
    } tlb_entry_t;

    typedef struct packed {
        logic              fault;
        logic [CODE_W-1:0] code;
        logic [VA_W-1:0]   paddr;
    } xlate_res_t;

    // Page-number bits that lie inside the page for a given size code.
    function automatic logic [PN_W-1:0] inpage_pn_bits(input logic [1:0] size);
        case (size)
            2'd0:    return PN_W'(0);
            2'd1:    return PN_W'(22'h3);
            2'd2:    return PN_W'(22'h3F);
            default: return PN_W'(22'h3FF);
        endcase
    endfunction

    function automatic logic [VA_W-1:0] offset_mask(input logic [1:0] size);
        return {inpage_pn_bits(size), {OFS_W{1'b1}}};
    endfunction

    function automatic logic [VA_W-1:0] low29(input logic [VA_W-1:0] va);
        return {3'b000, va[28:0]};
    endfunction

endpackage

// File: rtl/vtlb_store.sv
module vtlb_store
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [IDX_W-1:0] wr_index,
    input  tlb_entry_t wr_entry,
    output tlb_entry_t ent_q [ENTRIES]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_index == IDX_W'(i)) begin
                    ent_q[i] <= wr_entry;
                end
            end
        end
    end

endmodule

// File: rtl/vtlb_match.sv
module vtlb_match
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic [PN_W-1:0]   va_pn,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              asid_chk,
    input  tlb_entry_t        ent [ENTRIES],
    output logic              hit_any,
    output logic              hit_multi,
    output tlb_entry_t        hit_ent
);

    logic [ENTRIES-1:0] hit_vec;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            logic [PN_W-1:0] keep;
            logic            page_ok;
            logic            asid_ok;
            assign keep    = ~inpage_pn_bits(ent[g].size);
            assign page_ok = ((va_pn ^ ent[g].vpn) & keep) == '0;
            assign asid_ok = ent[g].share || !asid_chk || (ent[g].asid == cur_asid);
            assign hit_vec[g] = ent[g].valid && page_ok && asid_ok;
        end
    endgenerate

    assign hit_any   = |hit_vec;
    assign hit_multi = |(hit_vec & (hit_vec - 1'b1));

    always_comb begin
        hit_ent = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                hit_ent = hit_ent | ent[i];
            end
        end
    end

endmodule

// File: rtl/vtlb_resolve.sv
module vtlb_resolve
    import vtlb_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    input  acc_kind_e       kind,
    input  logic            priv,
    input  logic            xlate_en,
    input  logic            hit_any,
    input  logic            hit_multi,
    input  tlb_entry_t      hit_ent,
    output xlate_res_t      res
);

    logic is_wr;
    logic in_direct;
    logic in_top;
    logic in_user_win;
    logic [VA_W-1:0] pa_tlb;

    assign is_wr       = (kind == ACC_WRITE);
    assign in_direct   = (vaddr[31:30] == 2'b10);
    assign in_top      = (vaddr[31:29] == 3'b111);
    assign in_user_win = (vaddr[31:26] == 6'b111000);

    assign pa_tlb = ({hit_ent.ppn, {OFS_W{1'b0}}} & ~offset_mask(hit_ent.size))
                  | (vaddr & offset_mask(hit_ent.size));

    always_comb begin
        res = '0;
        if (in_direct || in_top) begin
            if (!priv && !in_user_win) begin
                res.fault = 1'b1;
                res.code  = is_wr ? EXC_ADDR_WR : EXC_ADDR_RD;
            end else begin
                res.paddr = in_direct ? low29(vaddr) : vaddr;
            end
        end else if (!xlate_en) begin
            res.paddr = low29(vaddr);
        end else if (hit_multi) begin
            res.fault = 1'b1;
            res.code  = EXC_MULTI;
        end else if (!hit_any) begin
            res.fault = 1'b1;
            res.code  = is_wr ? EXC_MISS_WR : EXC_MISS_RD;
        end else if (!priv && !hit_ent.prot[1]) begin
            res.fault = 1'b1;
            res.code  = is_wr ? EXC_PROT_WR : EXC_PROT_RD;
        end else if (is_wr && !hit_ent.prot[0]) begin
            res.fault = 1'b1;
            res.code  = EXC_PROT_WR;
        end else if (is_wr && !hit_ent.dirty) begin
            res.fault = 1'b1;
            res.code  = EXC_FIRST_WR;
        end else begin
            res.paddr = pa_tlb;
        end
    end

endmodule

// File: rtl/vtlb_xlate.sv
module vtlb_xlate
    import vtlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    input  logic [7:0]        cur_asid,
    input  logic              xlate_en,
    input  logic              single_virt,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [21:0]       wr_vpn,
    input  logic [21:0]       wr_ppn,
    input  logic [7:0]        wr_asid,
    input  logic [1:0]        wr_size,
    input  logic              wr_valid,
    input  logic              wr_share,
    input  logic [1:0]        wr_prot,
    input  logic              wr_dirty,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [11:0]       rsp_code,
    output logic [31:0]       rsp_paddr
);

    tlb_entry_t wr_entry;
    tlb_entry_t ent_q [ENTRIES];
    tlb_entry_t hit_ent;
    logic       hit_any;
    logic       hit_multi;
    logic       asid_chk;
    acc_kind_e  kind;
    xlate_res_t res_d;
    xlate_res_t res_q;

    always_comb begin
        wr_entry.valid = wr_valid;
        wr_entry.share = wr_share;
        wr_entry.size  = wr_size;
        wr_entry.prot  = wr_prot;
        wr_entry.dirty = wr_dirty;
        wr_entry.asid  = wr_asid;
        wr_entry.vpn   = wr_vpn;
        wr_entry.ppn   = wr_ppn;
    end

    assign kind     = (req_kind == 2'd3) ? ACC_READ : acc_kind_e'(req_kind);
    assign asid_chk = !(single_virt && req_priv);

    vtlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) i_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_index (wr_index),
        .wr_entry (wr_entry),
        .ent_q    (ent_q)
    );

    vtlb_match #(.ENTRIES(ENTRIES)) i_match (
        .va_pn     (req_vaddr[31:10]),
        .cur_asid  (cur_asid),
        .asid_chk  (asid_chk),
        .ent       (ent_q),
        .hit_any   (hit_any),
        .hit_multi (hit_multi),
        .hit_ent   (hit_ent)
    );

    vtlb_resolve i_resolve (
        .vaddr     (req_vaddr),
        .kind      (kind),
        .priv      (req_priv),
        .xlate_en  (xlate_en),
        .hit_any   (hit_any),
        .hit_multi (hit_multi),
        .hit_ent   (hit_ent),
        .res       (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign rsp_fault = res_q.fault;
    assign rsp_code  = res_q.code;
    assign rsp_paddr = res_q.paddr;

endmodule

// File: rtl/vtlb_xlate_chk.sv
module vtlb_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic [1:0]  req_kind,
    input logic        req_priv,
    input logic        xlate_en,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [11:0] rsp_code,
    input logic [31:0] rsp_paddr
);

    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    p_direct_window_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv && req_vaddr[31:30] == 2'b10)
        |=> (!rsp_fault && rsp_paddr == {3'b000, $past(req_vaddr[28:0])}));

    p_top_passthru_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_priv && req_vaddr[31:29] == 3'b111)
        |=> (!rsp_fault && rsp_paddr == $past(req_vaddr)));

    p_user_region_err_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_priv && (req_vaddr[31:30] == 2'b10 ||
         (req_vaddr[31:29] == 3'b111 && req_vaddr[28:26] != 3'b000)))
        |=> (rsp_fault && rsp_code == (($past(req_kind) == 2'd1) ? 12'h100 : 12'h0E0)));

    p_flat_when_off_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !xlate_en && (!req_vaddr[31] || req_vaddr[31:29] == 3'b110))
        |=> (!rsp_fault && rsp_paddr == {3'b000, $past(req_vaddr[28:0])}));

    p_fault_zero_pa_r13: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == 32'h0));

    p_code_legal_r13: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_code inside {12'h040, 12'h060, 12'h080,
            12'h0A0, 12'h0C0, 12'h0E0, 12'h100, 12'h140}));

endmodule

bind vtlb_xlate vtlb_xlate_chk i_chk (.*);

// File: tb/test_vtlb_xlate.sv
module test_vtlb_xlate;

    localparam int ENTRIES = 8;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [31:0]       req_vaddr;
    logic [1:0]        req_kind;
    logic              req_priv;
    logic [7:0]        cur_asid;
    logic              xlate_en;
    logic              single_virt;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_index;
    logic [21:0]       wr_vpn;
    logic [21:0]       wr_ppn;
    logic [7:0]        wr_asid;
    logic [1:0]        wr_size;
    logic              wr_valid;
    logic              wr_share;
    logic [1:0]        wr_prot;
    logic              wr_dirty;
    logic              rsp_valid;
    logic              rsp_fault;
    logic [11:0]       rsp_code;
    logic [31:0]       rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    vtlb_xlate #(.ENTRIES(ENTRIES)) i_vtlb_xlate (.*);

    // {vaddr, kind, priv, asid, xlate_en, single_virt, exp_fault, exp_code, exp_paddr}
    localparam int NV = 28;
    localparam logic [89:0] VECS [NV] = '{
        {32'h00400ABC, 2'd0, 1'b0, 8'd5, 1'b1, 1'b0, 1'b0, 12'h000, 32'h00123ABC}, // R6 R7 4K hit
        {32'h00400ABC, 2'd0, 1'b0, 8'd6, 1'b1, 1'b0, 1'b1, 12'h040, 32'h0},        // R7 R8 asid mismatch
        {32'h00400ABC, 2'd0, 1'b1, 8'd6, 1'b1, 1'b1, 1'b0, 12'h000, 32'h00123ABC}, // R7 single-virt priv
        {32'h00400ABC, 2'd0, 1'b0, 8'd6, 1'b1, 1'b1, 1'b1, 12'h040, 32'h0},        // R7 single-virt user
        {32'h100ABCDE, 2'd0, 1'b0, 8'd3, 1'b1, 1'b0, 1'b1, 12'h0A0, 32'h0},        // R10 user read
        {32'h100ABCDE, 2'd1, 1'b0, 8'd3, 1'b1, 1'b0, 1'b1, 12'h0C0, 32'h0},        // R10 user write
        {32'h100ABCDE, 2'd0, 1'b1, 8'd3, 1'b1, 1'b0, 1'b0, 12'h000, 32'h055ABCDE}, // R6 R7 1M shared
        {32'h200003FF, 2'd1, 1'b0, 8'd5, 1'b1, 1'b0, 1'b1, 12'h0C0, 32'h0},        // R11 read-only
        {32'h200003FF, 2'd0, 1'b0, 8'd5, 1'b1, 1'b0, 1'b0, 12'h000, 32'h00777FFF}, // R6 1K
        {32'h20000400, 2'd0, 1'b0, 8'd5, 1'b1, 1'b0, 1'b1, 12'h040, 32'h0},        // R6 R8 past 1K page
        {32'h3000FFFF, 2'd1, 1'b1, 8'd5, 1'b1, 1'b0, 1'b1, 12'h080, 32'h0},        // R11 clean page
        {32'h3000FFFF, 2'd2, 1'b0, 8'd5, 1'b1, 1'b0, 1'b0, 12'h000, 32'h00ABFFFF}, // R6 R11 64K fetch
        {32'h00500100, 2'd0, 1'b1, 8'd5, 1'b1, 1'b0, 1'b1, 12'h140, 32'h0},        // R9 double hit
        {32'h00500800, 2'd0, 1'b1, 8'd5, 1'b1, 1'b0, 1'b0, 12'h000, 32'h00200800}, // R9 single hit
        {32'h0060ABCD, 2'd0, 1'b1, 8'd0, 1'b1, 1'b0, 1'b0, 12'h000, 32'h00A1ABCD}, // R6 unaligned fields
        {32'h00700000, 2'd2, 1'b0, 8'd5, 1'b1, 1'b0, 1'b1, 12'h040, 32'h0},        // R8 fetch miss
        {32'h00700000, 2'd1, 1'b0, 8'd5, 1'b1, 1'b0, 1'b1, 12'h060, 32'h0},        // R8 write miss
        {32'h8ABCDEF0, 2'd0, 1'b1, 8'd0, 1'b1, 1'b0, 1'b0, 12'h000, 32'h0ABCDEF0}, // R2
        {32'hBFFFFFFF, 2'd1, 1'b1, 8'd0, 1'b1, 1'b0, 1'b0, 12'h000, 32'h1FFFFFFF}, // R2 top edge
        {32'hC0000000, 2'd0, 1'b1, 8'd0, 1'b1, 1'b0, 1'b1, 12'h040, 32'h0},        // R8 translated window
        {32'hF0001234, 2'd2, 1'b1, 8'd0, 1'b1, 1'b0, 1'b0, 12'h000, 32'hF0001234}, // R3
        {32'hE0000010, 2'd1, 1'b0, 8'd0, 1'b1, 1'b0, 1'b0, 12'h000, 32'hE0000010}, // R3 user window
        {32'hE3FFFFFC, 2'd3, 1'b0, 8'd0, 1'b1, 1'b0, 1'b0, 12'h000, 32'hE3FFFFFC}, // R3 R1 kind 3
        {32'hE4000000, 2'd1, 1'b0, 8'd0, 1'b1, 1'b0, 1'b1, 12'h100, 32'h0},        // R4 write
        {32'h80000000, 2'd2, 1'b0, 8'd0, 1'b1, 1'b0, 1'b1, 12'h0E0, 32'h0},        // R4 fetch
        {32'h90000000, 2'd0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b1, 12'h0E0, 32'h0},        // R4 translation off
        {32'h40001234, 2'd1, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 12'h000, 32'h00001234}, // R5 user write
        {32'hDFFFFFFF, 2'd0, 1'b1, 8'd0, 1'b0, 1'b0, 1'b0, 12'h000, 32'h1FFFFFFF}  // R5
    };

    task automatic check(input string tag, input logic [45:0] act, input logic [45:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_entry(input int idx, input logic [21:0] vpn, input logic [7:0] asid,
                              input logic [21:0] ppn, input logic [1:0] size, input logic v,
                              input logic sh, input logic [1:0] prot, input logic dirty);
        @(negedge clk);
        wr_en = 1'b1; wr_index = IDX_W'(idx); wr_vpn = vpn; wr_asid = asid; wr_ppn = ppn;
        wr_size = size; wr_valid = v; wr_share = sh; wr_prot = prot; wr_dirty = dirty;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drive a request, read its result one edge later, then idle one cycle.
    task automatic lookup(input logic [89:0] v, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = v[89:58]; req_kind = v[57:56]; req_priv = v[55];
        cur_asid = v[54:47]; xlate_en = v[46]; single_virt = v[45];
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, {rsp_valid, rsp_fault, rsp_code, rsp_paddr}, {1'b1, v[44:0]});
        @(negedge clk);
        check("R1 idle", {45'd0, rsp_valid}, 46'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0; req_priv = 1'b0;
        cur_asid = '0; xlate_en = 1'b1; single_virt = 1'b0; wr_en = 1'b0; wr_index = '0;
        wr_vpn = '0; wr_ppn = '0; wr_asid = '0; wr_size = '0; wr_valid = 1'b0;
        wr_share = 1'b0; wr_prot = '0; wr_dirty = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", {rsp_valid, rsp_fault, rsp_code, rsp_paddr}, 46'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {45'd0, rsp_valid}, 46'd0);
        lookup({32'h00400ABC, 2'd0, 1'b1, 8'd5, 1'b1, 1'b0, 1'b1, 12'h040, 32'h0}, "R12 empty table");

        load_entry(0, 22'h01000, 8'd5, 22'h0048C, 2'd1, 1'b1, 1'b0, 2'b11, 1'b1);
        load_entry(1, 22'h40000, 8'd9, 22'h15400, 2'd3, 1'b1, 1'b1, 2'b01, 1'b1);
        load_entry(2, 22'h80000, 8'd5, 22'h01DDF, 2'd0, 1'b1, 1'b0, 2'b10, 1'b1);
        load_entry(3, 22'hC0000, 8'd5, 22'h02AC0, 2'd2, 1'b1, 1'b0, 2'b11, 1'b0);
        load_entry(4, 22'h01400, 8'd0, 22'h00800, 2'd1, 1'b1, 1'b1, 2'b11, 1'b1);
        load_entry(5, 22'h01400, 8'd5, 22'h01000, 2'd0, 1'b1, 1'b0, 2'b11, 1'b1);
        load_entry(6, 22'h0180F, 8'd0, 22'h0284F, 2'd2, 1'b1, 1'b1, 2'b11, 1'b1);

        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i], $sformatf("vector %0d", i));
        end

        // R6: rewriting a slot replaces it; an invalid entry never matches (R7)
        load_entry(0, 22'h01000, 8'd5, 22'h0048C, 2'd1, 1'b0, 1'b0, 2'b11, 1'b1);
        lookup({32'h00400ABC, 2'd0, 1'b0, 8'd5, 1'b1, 1'b0, 1'b1, 12'h040, 32'h0}, "R6 R7 invalidated");
        load_entry(0, 22'h01000, 8'd5, 22'h00001, 2'd1, 1'b1, 1'b0, 2'b11, 1'b1);
        lookup({32'h00400ABC, 2'd0, 1'b0, 8'd5, 1'b1, 1'b0, 1'b0, 12'h000, 32'h00000ABC}, "R6 rewritten");

        // R12: reset clears the table
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        lookup({32'h100ABCDE, 2'd0, 1'b1, 8'd9, 1'b1, 1'b0, 1'b1, 12'h040, 32'h0}, "R12 after reset");
        lookup({32'h0060ABCD, 2'd1, 1'b1, 8'd0, 1'b1, 1'b0, 1'b1, 12'h060, 32'h0}, "R12 R8 after reset");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule